// File: doc/BRIEF.md
# UART FIFO Trigger-Level Controller

This block holds the transmit and receive byte queues of a serial port and turns their fill state into interrupt requests. The host writes one 8-bit control byte. That byte turns the queues on, selects DMA signalling, clears either queue, and picks a threshold for each direction from a small table. Characters come in from the receive shifter and go out to the transmit shifter through push and pop strobes. The host side uses the opposite ends of the same two queues.

The receive request rises once the stored count reaches the selected level. It also rises when the character-timeout pulse arrives. The transmit request is edge-driven. It fires when free space climbs back above the selected level. If a reload never filled the queue that far, it fires instead when the queue drains to empty. The host clears it by writing a byte or by acknowledging the interrupt status. The transmit table is used only while the enhanced-feature input is high.

Top module: `fifoTrigCtrl`

## Requirements
- R1: After reset both levels are 0, both requests and both overrun flags are 0, and the control readback is 0x00.
- R2: A control write stores bit 0 (queue enable, shown on `fifoEn`), bit 3 (DMA mode, shown on `dmaMode`), bits 5:4 (transmit select) and bits 7:6 (receive select). The readback returns these bits, and bits 2:1 always read 0.
- R3: A control write with bits 0 and 1 set empties the receive queue and clears its overrun flag at that edge. Bits 0 and 2 do the same for the transmit queue. With bit 0 clear, the clear bits have no effect.
- R4: Each queue returns bytes in arrival order. A pop from an empty queue reads 0 and leaves the level at 0.
- R5: A push into a full queue (64 entries) is dropped and sets that queue's sticky overrun flag. The stored bytes are kept.
- R6: While the enable bit is 0, pushes and pops are ignored and both levels hold.
- R7: `rxIrq` is high whenever the receive level is at or above the receive threshold. Bits 7:6 map 00→8, 01→16, 10→56, 11→60.
- R8: A `rxTimeout` pulse sets a pending flag that holds `rxIrq` high until a receive pop or a receive clear. A timeout in the same cycle as a pop leaves the flag set.
- R9: With `txEnhEn` high, bits 5:4 set the transmit threshold in free spaces: 00→8, 01→16, 10→32, 11→56. With `txEnhEn` low, the threshold is 8.
- R10: One cycle after the transmit level drops below 64 minus the threshold, having been at or above it, `txIrq` is set.
- R11: If the level did not reach 64 minus the threshold since the last event, `txIrq` is set one cycle after the level drains to 0.
- R12: `txIrq` is cleared by a host transmit write or by `isrRead`. A set event in the same cycle wins over the clear.
- R13: A transmit clear drops `txIrq` at once, and the level falling to 0 through that clear raises no empty event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Control byte write strobe |
| ctlWrData | input | 8 | Control byte |
| ctlRdData | output | 8 | Control readback |
| txEnhEn | input | 1 | Enables transmit threshold selection |
| txWrEn | input | 1 | Host push into transmit queue |
| txWrData | input | 8 | Host transmit byte |
| txRdEn | input | 1 | Shifter pop from transmit queue |
| txRdData | output | 8 | Transmit queue head (0 when empty) |
| rxWrEn | input | 1 | Shifter push into receive queue |
| rxWrData | input | 8 | Received byte |
| rxRdEn | input | 1 | Host pop from receive queue |
| rxRdData | output | 8 | Receive queue head (0 when empty) |
| rxTimeout | input | 1 | Character-timeout pulse |
| isrRead | input | 1 | Host interrupt-status acknowledge |
| txLevel | output | 7 | Transmit entries stored |
| rxLevel | output | 7 | Receive entries stored |
| txOverrun | output | 1 | Sticky transmit overrun |
| rxOverrun | output | 1 | Sticky receive overrun |
| rxIrq | output | 1 | Receive request |
| txIrq | output | 1 | Transmit request |
| fifoEn | output | 1 | Queue enable bit |
| dmaMode | output | 1 | DMA mode bit |

## Verification
The host acknowledge (`isrRead`) and the transmit threshold-crossing event can land on the same clock edge. The bench provokes this by popping the transmit queue from 56 to 55 entries and asserting `isrRead` in the very next cycle, which is when the set event is evaluated. It then expects `txIrq` to be high. A second collision pairs a receive pop with a timeout pulse, and `rxIrq` must stay high afterwards.

// File: rtl/uftc_pkg.sv
package uftc_pkg;

  typedef struct packed {
    logic rxClr;
    logic txClr;
    logic rxPush;
    logic rxPop;
    logic txPush;
    logic txPop;
  } strobeT;

  // receive threshold in stored characters
  function automatic int unsigned rxTrigLvl(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 56;
      default: return 60;
    endcase
  endfunction

  // transmit threshold in free spaces
  function automatic int unsigned txTrigLvl(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/uftcFifo.sv
module uftcFifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [CW-1:0]    level,
  output logic             overrun
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic full, empty, doPush, doPop;

  assign full   = (level == CW'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = empty ? '0 : mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else if (clr) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (push && full) overrun <= 1'b1;
      level <= level + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && doPush) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/uftcData.sv
module uftcData
  import uftc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [WIDTH-1:0] txWrData,
  input  logic [WIDTH-1:0] rxWrData,
  output logic [WIDTH-1:0] txRdData,
  output logic [WIDTH-1:0] rxRdData,
  output logic [CW-1:0]    txLevel,
  output logic [CW-1:0]    rxLevel,
  output logic             txOverrun,
  output logic             rxOverrun
);
  uftcFifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) txQ (
    .clk(clk), .rstN(rstN), .clr(stb.txClr), .push(stb.txPush), .pop(stb.txPop),
    .wrData(txWrData), .rdData(txRdData), .level(txLevel), .overrun(txOverrun)
  );

  uftcFifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) rxQ (
    .clk(clk), .rstN(rstN), .clr(stb.rxClr), .push(stb.rxPush), .pop(stb.rxPop),
    .wrData(rxWrData), .rdData(rxRdData), .level(rxLevel), .overrun(rxOverrun)
  );
endmodule

// File: rtl/uftcCtrl.sv
module uftcCtrl
  import uftc_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlWrEn,
  input  logic [7:0]    ctlWrData,
  input  logic          txEnhEn,
  input  logic          txWrEn,
  input  logic          txRdEn,
  input  logic          rxWrEn,
  input  logic          rxRdEn,
  input  logic          rxTimeout,
  input  logic          isrRead,
  input  logic [CW-1:0] txLevel,
  input  logic [CW-1:0] rxLevel,
  output strobeT        stb,
  output logic [7:0]    ctlRdData,
  output logic          rxIrq,
  output logic          txIrq,
  output logic          fifoEn,
  output logic          dmaMode
);
  logic [1:0] rxSel, txSel;
  logic toPend, filledPast;
  logic [CW-1:0] prevTxLevel, rxTrig, txTrig, txThr;
  logic below, riseEvt, emptyEvt;

  // control register; clear bits are never stored, so they read as 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEn  <= 1'b0;
      dmaMode <= 1'b0;
      txSel   <= 2'b00;
      rxSel   <= 2'b00;
    end else if (ctlWrEn) begin
      fifoEn  <= ctlWrData[0];
      dmaMode <= ctlWrData[3];
      txSel   <= ctlWrData[5:4];
      rxSel   <= ctlWrData[7:6];
    end
  end

  assign ctlRdData = {rxSel, txSel, dmaMode, 2'b00, fifoEn};

  always_comb begin
    stb.rxClr  = ctlWrEn && ctlWrData[0] && ctlWrData[1];
    stb.txClr  = ctlWrEn && ctlWrData[0] && ctlWrData[2];
    stb.rxPush = fifoEn && rxWrEn;
    stb.rxPop  = fifoEn && rxRdEn;
    stb.txPush = fifoEn && txWrEn;
    stb.txPop  = fifoEn && txRdEn;
  end

  // receive request
  assign rxTrig = CW'(rxTrigLvl(rxSel));
  assign rxIrq  = (rxLevel >= rxTrig) || toPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               toPend <= 1'b0;
    else if (stb.rxClr)      toPend <= 1'b0;
    else if (rxTimeout)      toPend <= 1'b1;
    else if (rxRdEn)         toPend <= 1'b0;
  end

  // transmit request: edge tracker on the level
  assign txTrig   = txEnhEn ? CW'(txTrigLvl(txSel)) : CW'(8);
  assign txThr    = CW'(DEPTH) - txTrig;
  assign below    = txLevel < txThr;
  assign riseEvt  = filledPast && below;
  assign emptyEvt = !filledPast && (txLevel == '0) && (prevTxLevel != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTxLevel <= '0;
      filledPast  <= 1'b0;
      txIrq       <= 1'b0;
    end else if (stb.txClr) begin
      prevTxLevel <= '0;
      filledPast  <= 1'b0;
      txIrq       <= 1'b0;
    end else begin
      prevTxLevel <= txLevel;
      if (!below)       filledPast <= 1'b1;
      else if (riseEvt) filledPast <= 1'b0;
      if (riseEvt || emptyEvt)   txIrq <= 1'b1;
      else if (txWrEn || isrRead) txIrq <= 1'b0;
    end
  end
endmodule

// File: rtl/fifoTrigCtrl.sv
module fifoTrigCtrl
  import uftc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  output logic [7:0]       ctlRdData,
  input  logic             txEnhEn,
  input  logic             txWrEn,
  input  logic [WIDTH-1:0] txWrData,
  input  logic             txRdEn,
  output logic [WIDTH-1:0] txRdData,
  input  logic             rxWrEn,
  input  logic [WIDTH-1:0] rxWrData,
  input  logic             rxRdEn,
  output logic [WIDTH-1:0] rxRdData,
  input  logic             rxTimeout,
  input  logic             isrRead,
  output logic [CW-1:0]    txLevel,
  output logic [CW-1:0]    rxLevel,
  output logic             txOverrun,
  output logic             rxOverrun,
  output logic             rxIrq,
  output logic             txIrq,
  output logic             fifoEn,
  output logic             dmaMode
);
  strobeT stb;

  uftcCtrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .txEnhEn(txEnhEn), .txWrEn(txWrEn), .txRdEn(txRdEn), .rxWrEn(rxWrEn),
    .rxRdEn(rxRdEn), .rxTimeout(rxTimeout), .isrRead(isrRead),
    .txLevel(txLevel), .rxLevel(rxLevel), .stb(stb), .ctlRdData(ctlRdData),
    .rxIrq(rxIrq), .txIrq(txIrq), .fifoEn(fifoEn), .dmaMode(dmaMode)
  );

  uftcData #(.DEPTH(DEPTH), .WIDTH(WIDTH)) data (
    .clk(clk), .rstN(rstN), .stb(stb), .txWrData(txWrData), .rxWrData(rxWrData),
    .txRdData(txRdData), .rxRdData(rxRdData), .txLevel(txLevel), .rxLevel(rxLevel),
    .txOverrun(txOverrun), .rxOverrun(rxOverrun)
  );
endmodule

// File: rtl/uftcChecker.sv
module uftcChecker
  import uftc_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          ctlWrEn,
  input logic          wrEnBit,
  input logic          wrRxClr,
  input logic          wrTxClr,
  input logic [1:0]    rxSelRb,
  input logic          fifoEn,
  input logic [CW-1:0] txLevel,
  input logic [CW-1:0] rxLevel,
  input logic          rxOverrun,
  input logic          rxIrq,
  input logic          txIrq
);
  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel <= CW'(DEPTH)) && (txLevel <= CW'(DEPTH)));

  a_r3_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn && wrEnBit && wrRxClr |=> (rxLevel == '0) && !rxOverrun);

  a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn && !ctlWrEn |=> $stable(rxLevel) && $stable(txLevel));

  a_r7_rx_trig: assert property (@(posedge clk) disable iff (!rstN)
    rxLevel >= CW'(rxTrigLvl(rxSelRb)) |-> rxIrq);

  a_r10_tx_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrq) |-> $past(txLevel) < CW'(DEPTH - 8));

  a_r13_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn && wrEnBit && wrTxClr |=> !txIrq && (txLevel == '0));
endmodule

bind fifoTrigCtrl uftcChecker #(.DEPTH(DEPTH)) checker_i (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .wrEnBit(ctlWrData[0]),
  .wrRxClr(ctlWrData[1]), .wrTxClr(ctlWrData[2]), .rxSelRb(ctlRdData[7:6]),
  .fifoEn(fifoEn), .txLevel(txLevel), .rxLevel(rxLevel), .rxOverrun(rxOverrun),
  .rxIrq(rxIrq), .txIrq(txIrq)
);

// File: tb/tb_fifoTrigCtrl.sv
module tb_fifoTrigCtrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctlWrEn = 0, txEnhEn = 0, txWrEn = 0, txRdEn = 0, rxWrEn = 0, rxRdEn = 0;
  logic rxTimeout = 0, isrRead = 0;
  logic [7:0] ctlWrData = 0, txWrData = 0, rxWrData = 0;
  logic [7:0] ctlRdData, txRdData, rxRdData;
  logic [6:0] txLevel, rxLevel;
  logic txOverrun, rxOverrun, rxIrq, txIrq, fifoEn, dmaMode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifoTrigCtrl dut (.*);

  typedef struct packed { logic [1:0] sel; logic [6:0] n; logic exp; } rxVecT;
  localparam rxVecT RXV [8] = '{
    '{2'd0, 7'd7, 1'b0}, '{2'd0, 7'd8, 1'b1}, '{2'd1, 7'd15, 1'b0}, '{2'd1, 7'd16, 1'b1},
    '{2'd2, 7'd55, 1'b0}, '{2'd2, 7'd56, 1'b1}, '{2'd3, 7'd59, 1'b0}, '{2'd3, 7'd60, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic ctlW(input logic [7:0] v);
    ctlWrEn = 1; ctlWrData = v; tick; ctlWrEn = 0;
  endtask

  task automatic rxPush(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin rxWrEn = 1; rxWrData = base + 8'(i); tick; end
    rxWrEn = 0;
  endtask

  task automatic txPush(input int n);
    for (int i = 0; i < n; i++) begin txWrEn = 1; txWrData = 8'(i); tick; end
    txWrEn = 0;
  endtask

  task automatic txPop(input int n);
    for (int i = 0; i < n; i++) begin txRdEn = 1; tick; end
    txRdEn = 0;
  endtask

  task automatic rxPopChk(input logic [7:0] exp, input string req);
    chk(req, rxRdData, exp); rxRdEn = 1; tick; rxRdEn = 0;
  endtask

  initial begin
    repeat (3) tick;
    // R1 reset state
    chk("R1 rxLevel", rxLevel, 0); chk("R1 txLevel", txLevel, 0);
    chk("R1 irqs", {rxIrq, txIrq, rxOverrun, txOverrun}, 0);
    chk("R1 ctlRdData", ctlRdData, 8'h00);
    rstN = 1; tick;

    // R2 control fields
    ctlW(8'h8F);
    chk("R2 readback", ctlRdData, 8'h89);
    chk("R2 enable/dma", {fifoEn, dmaMode}, 2'b11);

    // R7 receive threshold table
    foreach (RXV[k]) begin
      ctlW({RXV[k].sel, 6'b000011});
      rxPush(int'(RXV[k].n), 8'h00);
      chk($sformatf("R7 sel=%0d n=%0d", RXV[k].sel, RXV[k].n), rxIrq, RXV[k].exp);
    end

    // R4 ordering and empty pop
    ctlW(8'h03);
    rxPush(3, 8'hA0);
    rxPopChk(8'hA0, "R4 first"); rxPopChk(8'hA1, "R4 second"); rxPopChk(8'hA2, "R4 third");
    rxPopChk(8'h00, "R4 empty read");
    chk("R4 empty level", rxLevel, 0);

    // R5 overrun
    rxPush(65, 8'h00);
    chk("R5 full level", rxLevel, 64);
    chk("R5 overrun", rxOverrun, 1);
    rxPopChk(8'h00, "R5 head kept");

    // R3 clear ignored when enable bit clear; R6 disabled queue
    ctlW(8'h02);
    chk("R3 no clear without enable", rxLevel, 63);
    rxPush(2, 8'h55);
    chk("R6 push ignored", rxLevel, 63);
    ctlW(8'h03);
    chk("R3 rx clear", {rxLevel, rxOverrun}, 0);

    // R8 timeout pending
    rxTimeout = 1; tick; rxTimeout = 0;
    chk("R8 timeout irq", rxIrq, 1);
    rxPush(1, 8'h11);
    rxTimeout = 1; rxRdEn = 1; tick; rxTimeout = 0; rxRdEn = 0;
    chk("R8 timeout wins over pop", rxIrq, 1);
    rxRdEn = 1; tick; rxRdEn = 0;
    chk("R8 pop clears pending", rxIrq, 0);

    // R10 crossing, default threshold 8 (level mark 56)
    txEnhEn = 0;
    ctlW(8'h05);
    txPush(56); tick;
    chk("R10 no irq while full", txIrq, 0);
    txPop(1);
    chk("R10 not yet", txIrq, 0);
    tick;
    chk("R10 crossing irq", txIrq, 1);
    isrRead = 1; tick; isrRead = 0;
    chk("R12 ack clears", txIrq, 0);

    // R12 coincident set and acknowledge
    txPush(1);
    txRdEn = 1; tick; txRdEn = 0;
    isrRead = 1; tick; isrRead = 0;
    chk("R12 set wins over ack", txIrq, 1);
    txPush(1);
    chk("R12 write clears", txIrq, 0);

    // R11 empty event
    ctlW(8'h05);
    txPush(3); txPop(3);
    chk("R11 not yet", txIrq, 0);
    tick;
    chk("R11 empty irq", txIrq, 1);

    // R13 clear drops irq, no empty event
    txPush(56); txPop(1); tick;
    chk("R13 irq armed", txIrq, 1);
    ctlW(8'h05);
    chk("R13 cleared", {txIrq, txLevel}, 0);
    tick; tick;
    chk("R13 no empty event", txIrq, 0);

    // R9 enhanced selection 11 -> 56 spaces (level mark 8)
    txEnhEn = 1;
    ctlW(8'h35);
    txPush(8); txPop(1); tick;
    chk("R9 enhanced threshold", txIrq, 1);
    txEnhEn = 0;
    ctlW(8'h35);
    txPush(8); txPop(1); tick;
    chk("R9 selection ignored", txIrq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule